// File: doc/BRIEF.md
# Vblank-Paced Palette Bit Flasher

This block sends one captured diagnostic word out as a series of full-screen colours. It can be read with a camera when every other video output path has failed. It runs only in the pixel clock domain and takes all of its timing from the vertical-blank signal. It drives a palette colour override that the display applies to the whole screen, so no pixel has to pass through the framebuffer write path.

A word is offered on a valid/ready input. The block accepts the word only when it is idle, and it holds off any new word until the current one has been shown in full. Each data bit is shown for a fixed number of frames: white for a one, black for a zero. A blue separator symbol comes before every bit and after the last bit, so a viewer can find the bit boundaries even when several bits in a row have the same value.

The word input follows valid/ready rules. `word_ready` is high only while the block is idle. A word is taken on a clock edge where `word_valid` and `word_ready` are both high. While the block is busy, the source may hold `word_valid` high and change `word_data` freely. Nothing is taken until `word_ready` returns high.

Top module: `vbflash_top`

## Requirements
- R1: After reset, `busy` and `override_en` are 0, `override_rgb` is 24'h000000 and `word_ready` is 1.
- R2: On a clock edge with `word_valid` and `word_ready` both high, the block latches `word_data`. From the next cycle, `busy` and `override_en` are 1 and the first symbol (a separator) is shown.
- R3: The symbol colours are fixed: separator = 24'h0000FF (blue), data one = 24'hFFFFFF (white), data zero = 24'h000000 (black). `override_en` stays high for the whole transmission, and `override_rgb` is 24'h000000 whenever `override_en` is low.
- R4: The symbol order is: a separator, then the data bit, for each bit from bit W-1 down to bit 0, followed by one final separator. This makes 2W+1 symbols in total (33 with the default W=16).
- R5: Each symbol is held for exactly HOLD rising edges of `vblank` (default 20). The next symbol appears in the cycle after the clock edge that samples the HOLD-th rising edge.
- R6: `vblank` is edge-detected. A pulse of any length advances the hold count by exactly one, and nothing advances while `vblank` stays high or stays low.
- R7: In the cycle after the HOLD-th rising edge of the final separator, `busy` and `override_en` return to 0, `override_rgb` returns to 0 and `word_ready` returns to 1.
- R8: While `busy` is high, `word_ready` is 0. A word offered with `word_valid` during that time is not taken and does not change the symbol sequence.
- R9: Changes on `word_data` after the word has been accepted have no effect on the colours shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| vblank | input | 1 | Vertical-blank level, in the pixel clock domain |
| word_valid | input | 1 | A diagnostic word is offered |
| word_ready | output | 1 | The block is idle and will take a word |
| word_data | input | W | Diagnostic word to be shown |
| override_rgb | output | 24 | Palette colour for the whole screen |
| override_en | output | 1 | Apply `override_rgb` to the whole screen |
| busy | output | 1 | A transmission is in progress |

## Verification
The bench counts every symbol's dwell in vblank pulses. A timer that is off by one in either direction would change colour after the 19th pulse, or would still show the old colour after the 20th pulse. Long vblank pulses check that the block does not count a level instead of an edge, which would race through the symbols. Words made of all zeros, all ones and alternating patterns check the bit order and the separators. A reversed or shifted sequence would show the wrong colour at the first bit that differs. A second word offered mid-stream, together with changes on the data bus, checks that the block does not restart or pick up new data while busy.

// File: rtl/vbflash_pkg.sv
package vbflash_pkg;

  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_SEP  = 2'd1,
    SYM_ONE  = 2'd2,
    SYM_ZERO = 2'd3
  } sym_e;

  localparam logic [23:0] RGB_SEP  = 24'h0000FF;
  localparam logic [23:0] RGB_ONE  = 24'hFFFFFF;
  localparam logic [23:0] RGB_ZERO = 24'h000000;
  localparam logic [23:0] RGB_OFF  = 24'h000000;

  function automatic logic [23:0] sym_colour(input sym_e s);
    case (s)
      SYM_SEP:  return RGB_SEP;
      SYM_ONE:  return RGB_ONE;
      SYM_ZERO: return RGB_ZERO;
      default:  return RGB_OFF;
    endcase
  endfunction

endpackage

// File: rtl/vbflash_edge.sv
module vbflash_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/vbflash_hold.sv
module vbflash_hold #(
  parameter int HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expire
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  assign expire = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  cnt <= '0;
    else if (expire)      cnt <= '0;
    else if (tick)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vbflash_seq.sv
module vbflash_seq
  import vbflash_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] word,
  input  logic         step,
  output logic         busy,
  output sym_e         sym
);
  localparam int NSYM = 2 * W + 1;
  localparam int IW   = $clog2(NSYM + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NSYM - 1);

  logic [W-1:0]  shreg;
  logic [IW-1:0] idx;
  logic          on_data;

  assign on_data = idx[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '0;
      idx   <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      shreg <= word;
      idx   <= '0;
    end else if (busy && step) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
        if (on_data) shreg <= {shreg[W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    if (!busy)        sym = SYM_NONE;
    else if (on_data) sym = shreg[W-1] ? SYM_ONE : SYM_ZERO;
    else              sym = SYM_SEP;
  end
endmodule

// File: rtl/vbflash_top.sv
module vbflash_top
  import vbflash_pkg::*;
#(
  parameter int W    = 16,
  parameter int HOLD = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vblank,
  input  logic         word_valid,
  output logic         word_ready,
  input  logic [W-1:0] word_data,
  output logic [23:0]  override_rgb,
  output logic         override_en,
  output logic         busy
);
  logic vb_rise;
  logic accept;
  logic expire;
  logic seq_busy;
  sym_e sym;

  assign word_ready = ~seq_busy;
  assign accept     = word_valid & ~seq_busy;

  vbflash_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (vblank),
    .rise  (vb_rise)
  );

  vbflash_hold #(.HOLD(HOLD)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .tick   (vb_rise & seq_busy),
    .expire (expire)
  );

  vbflash_seq #(.W(W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .word   (word_data),
    .step   (expire),
    .busy   (seq_busy),
    .sym    (sym)
  );

  assign busy         = seq_busy;
  assign override_en  = (sym != SYM_NONE);
  assign override_rgb = sym_colour(sym);
endmodule

// File: rtl/vbflash_check.sv
module vbflash_check #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         vblank,
  input logic         word_valid,
  input logic         word_ready,
  input logic [W-1:0] word_data,
  input logic [23:0]  override_rgb,
  input logic         override_en,
  input logic         busy
);
  logic vb_prev;
  logic vb_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) vb_prev <= 1'b0;
    else        vb_prev <= vblank;
  end
  assign vb_edge = vblank & ~vb_prev;

  // R2
  assert_accept_shows_sep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (busy && override_en && override_rgb == 24'h0000FF));

  // R3
  assert_legal_colour_R3: assert property (@(posedge clk) disable iff (!rst_n)
    override_en |-> (override_rgb == 24'h0000FF || override_rgb == 24'hFFFFFF ||
                     override_rgb == 24'h000000));

  // R3
  assert_dark_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !override_en |-> (override_rgb == 24'h000000));

  // R6
  assert_no_edge_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vb_edge) |=> (busy && $stable(override_rgb)));

  // R8
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !word_ready);

  // R7
  assert_release_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(vb_edge) && !override_en));
endmodule

bind vbflash_top vbflash_check #(.W(W)) u_vbflash_check (
  .clk          (clk),
  .rst_n        (rst_n),
  .vblank       (vblank),
  .word_valid   (word_valid),
  .word_ready   (word_ready),
  .word_data    (word_data),
  .override_rgb (override_rgb),
  .override_en  (override_en),
  .busy         (busy)
);

// File: tb/vbflash_top_bench.sv
`timescale 1ns/1ps
module vbflash_top_bench;
  localparam int W    = 16;
  localparam int HOLD = 20;
  localparam int NVEC = 4;
  localparam logic [W-1:0] VEC [NVEC] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vblank = 1'b0;
  logic         word_valid = 1'b0;
  logic         word_ready;
  logic [W-1:0] word_data = '0;
  logic [23:0]  override_rgb;
  logic         override_en;
  logic         busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  vbflash_top #(.W(W), .HOLD(HOLD)) u_vbflash_top (
    .clk, .rst_n, .vblank, .word_valid, .word_ready, .word_data,
    .override_rgb, .override_en, .busy
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_colour(input logic [W-1:0] w, input int s);
    if (s % 2 == 0) return 24'h0000FF;
    return w[W-1-(s-1)/2] ? 24'hFFFFFF : 24'h000000;
  endfunction

  task automatic pulse(input int len);
    @(negedge clk) vblank = 1'b1;
    for (int i = 1; i < len; i++) @(negedge clk);
    @(negedge clk) vblank = 1'b0;
    @(negedge clk);
  endtask

  // long_len > 1 holds vblank high for several cycles (R6)
  // disturb: offer another word and wiggle the data mid-stream (R8, R9)
  task automatic send_word(input logic [W-1:0] w, input int long_len, input bit disturb);
    @(negedge clk);
    word_data  = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    chk("R2 busy after accept", {31'd0, busy}, 32'd1);
    chk("R3 enable high", {31'd0, override_en}, 32'd1);
    for (int s = 0; s < 2 * W + 1; s++) begin
      chk($sformatf("R4 symbol %0d colour", s), {8'd0, override_rgb}, {8'd0, exp_colour(w, s)});
      if (disturb && s == 3) begin
        word_valid = 1'b1;
        word_data  = ~w;
        @(negedge clk);
        chk("R8 ready low while busy", {31'd0, word_ready}, 32'd0);
      end
      if (disturb && s == 9) begin
        word_valid = 1'b0;
        word_data  = 16'h5A5A;
      end
      for (int p = 0; p < HOLD - 1; p++) pulse(long_len);
      chk($sformatf("R5 symbol %0d held 19 pulses", s), {8'd0, override_rgb},
          {8'd0, exp_colour(w, s)});
      chk("R3 enable held", {31'd0, override_en}, 32'd1);
      if (disturb && s == 12)
        chk("R9 data change ignored", {8'd0, override_rgb}, {8'd0, exp_colour(w, s)});
      pulse(long_len);
    end
    chk("R7 busy released", {31'd0, busy}, 32'd0);
    chk("R7 enable released", {31'd0, override_en}, 32'd0);
    chk("R7 colour off", {8'd0, override_rgb}, 32'd0);
    chk("R7 ready back", {31'd0, word_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 enable", {31'd0, override_en}, 32'd0);
    chk("R1 rgb", {8'd0, override_rgb}, 32'd0);
    chk("R1 ready", {31'd0, word_ready}, 32'd1);

    // R6: pulses while idle change nothing
    pulse(1); pulse(4);
    chk("R6 idle pulses no effect", {31'd0, override_en}, 32'd0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) send_word(VEC[v], 1, 1'b0);

    // R6: long vblank pulses count once each
    send_word(16'h6C39, 7, 1'b0);

    // R8, R9: second offer and data changes while busy
    send_word(16'h1E87, 1, 1'b1);

    // R6: vblank held high across accept, no spurious step
    @(negedge clk) vblank = 1'b1;
    word_data = 16'h8000; word_valid = 1'b1;
    @(negedge clk) word_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 level high no step", {8'd0, override_rgb}, 32'h0000FF);
    vblank = 1'b0;
    @(negedge clk);
    for (int p = 0; p < HOLD - 1; p++) pulse(1);
    chk("R5 first sep still shown", {8'd0, override_rgb}, 32'h0000FF);
    pulse(1);
    chk("R4 MSB one shown white", {8'd0, override_rgb}, 32'hFFFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule